// File: doc/BRIEF.md
# Timer Capture and Compare Unit

This unit sits beside a free-running 16-bit timer and owns one bidirectional pin. A 4-bit mode input chooses what the unit does. In the capture modes, a chosen edge on the pin stores the current timer value into a capture register. The edge can be every falling edge, every rising edge, or every 4th or 16th rising edge through an edge prescaler. In the compare modes, the timer is checked against a compare value. On a match the unit toggles the pin, sets it, clears it, raises only the interrupt flag, or sends a one-cycle pulse back to the timer to restart its count.

The pin input is asynchronous and passes through a two-flop synchronizer before edge detection. The interrupt flag is sticky and is cleared by a pulse on a dedicated input. The output-enable tells the pad ring when the unit drives the pin. In all other modes the pin is left to general I/O. Pulse-width generation is not part of this unit.

Top module: `capcmp_unit`

## Requirements
- R1: With mode 0000 the unit is off. After one clock, the capture value is 0, the pin output is 0, the flag is 0 and the timer-reset pulse is 0. The output-enable is 0 in this mode.
- R2: Modes 0001, 0011 and 11xx are inert. Pin edges capture nothing, a timer/compare match raises no flag, and the output-enable is 0.
- R3: In mode 0101 a rising edge of the pin, and in mode 0100 a falling edge, stores the timer value. The value stored is the one present at the third rising clock edge after the pin changes. The opposite edge has no effect on the capture value.
- R4: Mode 0110 captures on every 4th rising pin edge. Mode 0111 captures on every 16th rising pin edge.
- R5: Any change of mode clears the edge prescaler. The first capture after a mode change therefore needs the full 4 or 16 rising edges.
- R6: Every capture and every compare match sets the interrupt flag. The flag then stays set until a cycle with the clear input high and no new event. If an event and a clear happen in the same cycle, the flag stays set.
- R7: A compare match fires once, on the first clock where the timer equals the compare value. It does not fire again while that equality holds. It does not fire in the clock where the mode changes, nor when the equality already held when the mode was entered.
- R8: Mode 0010 drives the pin, starts it low on entry, and inverts it on every match.
- R9: Mode 1000 drives the pin low on entry and sets it high on a match.
- R10: Mode 1001 drives the pin high on entry and clears it low on a match.
- R11: Modes 1010 and 1011 do not drive the pin (output-enable 0). In mode 1010 a match only raises the flag.
- R12: In mode 1011 a match raises the flag and produces a timer-reset pulse exactly one clock wide, in the clock after the match.
- R13: The output-enable is 1 in modes 0010, 1000 and 1001, and 0 in every other mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 4 | Function select |
| timer_val | input | 16 | Current timer count |
| cmp_val | input | 16 | Compare value |
| pin_in | input | 1 | Asynchronous pin level from the pad |
| flag_clr | input | 1 | Clear pulse for the interrupt flag |
| cap_val | output | 16 | Last captured timer value |
| pin_out | output | 1 | Pin level driven when enabled |
| pin_oe | output | 1 | Pin output-enable |
| irq_flag | output | 1 | Sticky interrupt flag |
| tmr_reset | output | 1 | One-clock request to restart the timer |

## Verification
On every cycle, the assertions check the following:
- The off mode clears all outputs.
- The capture value stays frozen outside the capture modes.
- The flag stays set until it is cleared.
- The timer-reset pulse is one clock wide and comes only from the special-event mode.
- The pin starts at its entry level in the set and clear modes.
- The interrupt-only and special-event modes never drive the pin.

The following can only be shown by the bench scenarios:
- Edge counting through the prescaler.
- The prescaler clearing on a mode change.
- The exact latency of the synchronizer.
- The single firing of a match against a timer that holds its value.
- The sequence of pin levels under toggle, set and clear.
- Set-over-clear priority on the flag.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

    localparam logic [3:0] M_OFF      = 4'b0000;
    localparam logic [3:0] M_TOGGLE   = 4'b0010;
    localparam logic [3:0] M_CAP_FALL = 4'b0100;
    localparam logic [3:0] M_CAP_RISE = 4'b0101;
    localparam logic [3:0] M_CAP_R4   = 4'b0110;
    localparam logic [3:0] M_CAP_R16  = 4'b0111;
    localparam logic [3:0] M_CMP_SET  = 4'b1000;
    localparam logic [3:0] M_CMP_CLR  = 4'b1001;
    localparam logic [3:0] M_CMP_IRQ  = 4'b1010;
    localparam logic [3:0] M_CMP_TRIG = 4'b1011;

    localparam int PRE_SMALL = 4;
    localparam int PRE_LARGE = 16;
    localparam int PRE_W     = $clog2(PRE_LARGE);

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_TOGGLE,
        ACT_SET,
        ACT_CLR,
        ACT_IRQ,
        ACT_TRIG
    } cmp_act_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic cmp_act_e decode_act(input logic [3:0] m);
        case (m)
            M_TOGGLE:   return ACT_TOGGLE;
            M_CMP_SET:  return ACT_SET;
            M_CMP_CLR:  return ACT_CLR;
            M_CMP_IRQ:  return ACT_IRQ;
            M_CMP_TRIG: return ACT_TRIG;
            default:    return ACT_NONE;
        endcase
    endfunction

    function automatic logic drives_pin(input logic [3:0] m);
        return (m == M_TOGGLE) || (m == M_CMP_SET) || (m == M_CMP_CLR);
    endfunction

endpackage

// File: rtl/capcmp_edge.sv
module capcmp_edge
    import capcmp_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pin,
    output edge_t edg
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], pin};
    end

    // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous sample
    always_comb begin
        edg.rise = sh[STAGES-1] & ~sh[STAGES];
        edg.fall = ~sh[STAGES-1] & sh[STAGES];
    end
endmodule

// File: rtl/capcmp_capture.sv
module capcmp_capture
    import capcmp_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    mode,
    input  logic          mode_chg,
    input  edge_t         edg,
    input  logic [TW-1:0] timer,
    output logic [TW-1:0] cap_val,
    output logic          cap_evt
);
    logic [PRE_W-1:0] cnt;
    logic             qualified;
    logic             counting;
    logic             hit;

    always_comb begin
        counting = (mode == M_CAP_R4) || (mode == M_CAP_R16);
        case (mode)
            M_CAP_FALL: qualified = edg.fall;
            M_CAP_RISE: qualified = edg.rise;
            M_CAP_R4:   qualified = edg.rise && (cnt == PRE_W'(PRE_SMALL - 1));
            M_CAP_R16:  qualified = edg.rise && (cnt == PRE_W'(PRE_LARGE - 1));
            default:    qualified = 1'b0;
        endcase
        hit = qualified && !mode_chg;
    end

    always_ff @(posedge clk) begin
        if (rst || mode == M_OFF) begin
            cnt     <= '0;
            cap_val <= '0;
        end else if (mode_chg) begin
            cnt <= '0;
        end else begin
            if (counting && edg.rise) cnt <= hit ? '0 : cnt + 1'b1;
            if (hit) cap_val <= timer;
        end
    end

    assign cap_evt = hit;
endmodule

// File: rtl/capcmp_compare.sv
module capcmp_compare
    import capcmp_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    mode,
    input  logic          mode_chg,
    input  logic [TW-1:0] timer,
    input  logic [TW-1:0] cmp,
    output logic          pin_q,
    output logic          trig_q,
    output logic          match_evt
);
    cmp_act_e act;
    logic     eq;
    logic     eq_q;

    always_comb begin
        act       = decode_act(mode);
        eq        = (timer == cmp);
        match_evt = eq && !eq_q && !mode_chg && (act != ACT_NONE);
    end

    always_ff @(posedge clk) begin
        if (rst) eq_q <= 1'b0;
        else     eq_q <= eq;
    end

    always_ff @(posedge clk) begin
        if (rst || mode == M_OFF) begin
            pin_q  <= 1'b0;
            trig_q <= 1'b0;
        end else begin
            trig_q <= match_evt && (act == ACT_TRIG);
            if (mode_chg) begin
                pin_q <= (act == ACT_CLR);
            end else if (match_evt) begin
                case (act)
                    ACT_TOGGLE: pin_q <= ~pin_q;
                    ACT_SET:    pin_q <= 1'b1;
                    ACT_CLR:    pin_q <= 1'b0;
                    default:    pin_q <= pin_q;
                endcase
            end
        end
    end
endmodule

// File: rtl/capcmp_unit.sv
module capcmp_unit
    import capcmp_pkg::*;
#(
    parameter int TW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    mode,
    input  logic [TW-1:0] timer_val,
    input  logic [TW-1:0] cmp_val,
    input  logic          pin_in,
    input  logic          flag_clr,
    output logic [TW-1:0] cap_val,
    output logic          pin_out,
    output logic          pin_oe,
    output logic          irq_flag,
    output logic          tmr_reset
);
    logic [3:0] mode_q;
    logic       mode_chg;
    edge_t      edg;
    logic       cap_evt;
    logic       match_evt;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= M_OFF;
        else     mode_q <= mode;
    end

    assign mode_chg = (mode != mode_q);

    capcmp_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk (clk),
        .rst (rst),
        .pin (pin_in),
        .edg (edg)
    );

    capcmp_capture #(.TW(TW)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .mode_chg (mode_chg),
        .edg      (edg),
        .timer    (timer_val),
        .cap_val  (cap_val),
        .cap_evt  (cap_evt)
    );

    capcmp_compare #(.TW(TW)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .mode_chg  (mode_chg),
        .timer     (timer_val),
        .cmp       (cmp_val),
        .pin_q     (pin_out),
        .trig_q    (tmr_reset),
        .match_evt (match_evt)
    );

    // sticky flag: a new event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst || mode == M_OFF)      irq_flag <= 1'b0;
        else if (cap_evt || match_evt) irq_flag <= 1'b1;
        else if (flag_clr)             irq_flag <= 1'b0;
    end

    assign pin_oe = drives_pin(mode);
endmodule

// File: rtl/capcmp_checker.sv
module capcmp_checker #(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [3:0]    mode,
    input logic          flag_clr,
    input logic [TW-1:0] cap_val,
    input logic          pin_out,
    input logic          pin_oe,
    input logic          irq_flag,
    input logic          tmr_reset
);
    a_r1_off_clears: assert property (@(posedge clk) disable iff (rst)
        (mode == 4'b0000) |=> (cap_val == '0 && !irq_flag && !pin_out && !tmr_reset));

    a_r3_cap_frozen: assert property (@(posedge clk) disable iff (rst)
        (mode[3:2] != 2'b01 && mode != 4'b0000) |=> $stable(cap_val));

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !flag_clr && mode != 4'b0000) |=> irq_flag);

    a_r9_set_entry_low: assert property (@(posedge clk) disable iff (rst)
        (mode == 4'b1000 && $past(mode) != 4'b1000) |=> !pin_out);

    a_r10_clr_entry_high: assert property (@(posedge clk) disable iff (rst)
        (mode == 4'b1001 && $past(mode) != 4'b1001) |=> pin_out);

    a_r11_no_drive: assert property (@(posedge clk) disable iff (rst)
        (mode == 4'b1010 || mode == 4'b1011) |-> !pin_oe);

    a_r12_trig_one_cycle: assert property (@(posedge clk) disable iff (rst)
        tmr_reset |=> !tmr_reset);

    a_r12_trig_source: assert property (@(posedge clk) disable iff (rst)
        tmr_reset |-> ($past(mode) == 4'b1011));
endmodule

bind capcmp_unit capcmp_checker #(.TW(TW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .flag_clr  (flag_clr),
    .cap_val   (cap_val),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_flag  (irq_flag),
    .tmr_reset (tmr_reset)
);

// File: tb/capcmp_unit_test.sv
module capcmp_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  mode;
    logic [15:0] timer_val;
    logic [15:0] cmp_val;
    logic        pin_in;
    logic        flag_clr;
    logic [15:0] cap_val;
    logic        pin_out;
    logic        pin_oe;
    logic        irq_flag;
    logic        tmr_reset;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    capcmp_unit uut (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .timer_val (timer_val),
        .cmp_val   (cmp_val),
        .pin_in    (pin_in),
        .flag_clr  (flag_clr),
        .cap_val   (cap_val),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq_flag  (irq_flag),
        .tmr_reset (tmr_reset)
    );

    typedef struct packed {
        logic [3:0]  m;
        logic [15:0] t;
        logic [15:0] c;
        logic        clr;
        logic        pin;
        logic        oe;
        logic        flg;
        logic        trg;
    } vec_t;

    // one row per clock; expected {pin,oe,flag,trig} after that clock
    localparam vec_t TBL [0:20] = '{
        '{4'h8, 16'd5,  16'd10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R9 entry low
        '{4'h8, 16'd9,  16'd10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{4'h8, 16'd10, 16'd10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R9 match sets
        '{4'h8, 16'd10, 16'd10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R7 held
        '{4'h0, 16'd10, 16'd10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R1
        '{4'h9, 16'd3,  16'd10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R10 entry high
        '{4'h9, 16'd10, 16'd10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R10 match clears
        '{4'h0, 16'd0,  16'd10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'hB, 16'd20, 16'd21, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R12 entry
        '{4'hB, 16'd21, 16'd21, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R12 pulse
        '{4'hB, 16'd0,  16'd21, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R12 one wide
        '{4'h0, 16'd0,  16'd21, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'h2, 16'd1,  16'd2,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R8 entry low
        '{4'h2, 16'd2,  16'd2,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R8 toggle
        '{4'h2, 16'd3,  16'd2,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        '{4'h2, 16'd2,  16'd2,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R8 toggle back
        '{4'hA, 16'd7,  16'd7,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 entry equal
        '{4'hA, 16'd7,  16'd7,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 no late fire
        '{4'hA, 16'd8,  16'd7,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'hA, 16'd7,  16'd7,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R11 flag only
        '{4'hA, 16'd7,  16'd7,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0}  // R6 clear
    };

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [15:0] v);
        timer_val = v;
        pin_in = 1'b1;
        repeat (3) step();
        pin_in = 1'b0;
        repeat (3) step();
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; mode = 4'h0; timer_val = '0; cmp_val = '0;
        pin_in = 1'b0; flag_clr = 1'b0;
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R1 reset cap", 32'(cap_val), 32'd0);
        chk("R1 reset outputs", {pin_out, pin_oe, irq_flag, tmr_reset}, 32'd0);

        for (int i = 0; i < 21; i++) begin
            mode = TBL[i].m; timer_val = TBL[i].t; cmp_val = TBL[i].c;
            flag_clr = TBL[i].clr;
            step();
            chk($sformatf("table row %0d (R7/R8/R9/R10/R11/R12/R13)", i),
                {pin_out, pin_oe, irq_flag, tmr_reset},
                {TBL[i].pin, TBL[i].oe, TBL[i].flg, TBL[i].trg});
        end
        flag_clr = 1'b0;

        // R3 rising capture and its latency
        mode = 4'h5; timer_val = 16'd100; step();
        pin_in = 1'b1; step(); step();
        chk("R3 not yet captured", 32'(cap_val), 32'd0);
        step();
        chk("R3 rising capture", 32'(cap_val), 32'd100);
        chk("R6 flag on capture", 32'(irq_flag), 32'd1);
        timer_val = 16'd111; pin_in = 1'b0; repeat (3) step();
        chk("R3 falling ignored in rising mode", 32'(cap_val), 32'd100);

        // R6 set wins over clear
        timer_val = 16'd120; pin_in = 1'b1; step(); step();
        flag_clr = 1'b1; step(); flag_clr = 1'b0;
        chk("R6 set beats clear", {16'(irq_flag), cap_val}, {16'd1, 16'd120});
        clear_flag();
        chk("R6 clear alone", 32'(irq_flag), 32'd0);

        // R3 falling mode
        mode = 4'h4; step();
        timer_val = 16'd200; pin_in = 1'b0; repeat (3) step();
        chk("R3 falling capture", 32'(cap_val), 32'd200);
        timer_val = 16'd250; pin_in = 1'b1; repeat (4) step();
        chk("R3 rising ignored in falling mode", 32'(cap_val), 32'd200);
        pin_in = 1'b0; repeat (3) step();

        // R4 every 4th rising edge
        mode = 4'h6; timer_val = 16'd290; step();
        for (int k = 1; k <= 3; k++) pulse(16'(300 + k));
        chk("R4 no capture before 4th edge", 32'(cap_val), 32'd250);
        pulse(16'd304);
        chk("R4 capture on 4th edge", 32'(cap_val), 32'd304);

        // R5 prescaler cleared by mode change, then R4 every 16th edge
        pulse(16'd305); pulse(16'd306);
        mode = 4'h7; step();
        for (int k = 1; k <= 15; k++) pulse(16'(400 + k));
        chk("R5 count restarted after mode change", 32'(cap_val), 32'd304);
        pulse(16'd416);
        chk("R4 capture on 16th edge", 32'(cap_val), 32'd416);

        // R1 off clears capture and flag
        mode = 4'h0; step();
        chk("R1 off clears", {15'(0), irq_flag, cap_val}, 32'd0);

        // R2 inert modes
        mode = 4'h1; timer_val = 16'd500; cmp_val = 16'd501; step();
        timer_val = 16'd501; step();
        pulse(16'd600);
        chk("R2 mode 0001 inert", {13'(0), pin_oe, irq_flag, pin_out, cap_val}, 32'd0);
        mode = 4'hC; timer_val = 16'd700; step();
        timer_val = 16'd501; step();
        pulse(16'd650);
        chk("R2 mode 1100 inert", {13'(0), pin_oe, irq_flag, pin_out, cap_val}, 32'd0);
        mode = 4'h3; step();
        pulse(16'd660);
        chk("R2 mode 0011 inert R13", {14'(0), pin_oe, irq_flag, cap_val}, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule